// File: doc/BRIEF.md
# Dual-Channel Serial Word Assembler with Half-Word Readout

This block sits behind two serial bit samplers. Each channel receives validated bits, one per `bit_vld` strobe, and shifts them into a word register with the first received bit landing in the least significant position. An end-of-word pulse from the sampler closes the word. On that pulse the block checks parity across all 32 received bits and writes the result into the top bit in place of the received bit. It can also discard the word when two label bits do not match a programmed pair.

Each accepted word is copied into a per-channel holding register, and that channel's active-low ready flag drops. A host reads the held word as two 16-bit halves over one shared bus. A per-channel read enable picks the channel and `sel` picks the half. The ready flag rises again only after the low half and then the high half have been read. A word that arrives before the reads are complete replaces the held word and restarts the read sequence.

Top module: `wordrx_dual_top`

## Requirements
- R1: Serial bits are assembled so that the first bit received after reset or after the previous word lands in stored bit 0, and the 32nd lands in stored bit 31.
- R2: The stored bit 31 is 0 when the count of ones over all 32 received bits, the last one included, is odd, and 1 when it is even.
- R3: With `filt_en` high, a word is accepted only if received bit 8 equals `filt_bits[0]` and received bit 9 equals `filt_bits[1]`. A rejected word leaves the held word and `rdy_n` unchanged.
- R4: With `filt_en` low, every end-of-word pulse is accepted.
- R5: When a word is accepted on the clock edge that samples `eos`, the held word is loaded and `rdy_n` for that channel reads 0 after that edge.
- R6: A read with `sel`=0 returns stored bits 15..0 and a read with `sel`=1 returns stored bits 31..16. `dout` and `dout_vld` are registered and valid one cycle after the edge that samples the enable.
- R7: `rdy_n` returns to 1 on the edge that samples the enable low after a high-half read, provided a complete low-half read has finished since the last accepted word. The half is the `sel` value seen in the last enabled cycle.
- R8: A high-half read without a prior low-half read leaves `rdy_n` unchanged.
- R9: A word accepted before both halves are read overwrites the held word, keeps `rdy_n` at 0 and discards any low-half read already done. An acceptance also takes priority over a read ending on the same edge.
- R10: `dout_vld` is 0 in the cycle after no enable was active. When both enables are active, channel 0 drives the bus.
- R11: After reset, both `rdy_n` bits are 1, `dout_vld` is 0 and both held words are zero.
- R12: An end-of-word pulse that coincides with a bit strobe evaluates the word as it stood before that bit was shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | NCH | Per-channel strobe for a validated bit |
| bit_val | input | NCH | Per-channel bit value |
| eos | input | NCH | Per-channel end-of-word pulse |
| filt_en | input | 1 | Label filter enable |
| filt_bits | input | 2 | Required values of received bits 8 and 9 |
| rd_en | input | NCH | Per-channel read enable, active high |
| sel | input | 1 | Half select: 0 low half, 1 high half |
| dout | output | WORD_W/2 | Registered read data |
| dout_vld | output | 1 | Bus driven (stands in for tri-state) |
| rdy_n | output | NCH | Per-channel data-ready flag, active low |

## Verification
The bench builds the block with its defaults: two channels, a 32-bit word and the label pair at bits 8 and 9. With these values both channels can compete for the bus, so the channel-0 priority can be exercised. Parity can be driven through both odd and even totals, and the filter sees all four label combinations. Directed sequences cover a read order that must not clear the flag, an overwrite in the middle of a read, and an end-of-word pulse that coincides with a bit strobe. A randomized phase interleaves words and reads on both channels.

// File: rtl/wordrx_pkg.sv
package wordrx_pkg;
  localparam int LBL_W = 2;

  typedef struct packed {
    logic vld;
    logic val;
    logic eos;
  } ser_in_t;
endpackage

// File: rtl/wordrx_shifter.sv
module wordrx_shifter
  import wordrx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LBL_LO = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ser_in_t           sin,
  input  logic              filt_en,
  input  logic [LBL_W-1:0]  filt_bits,
  output logic              acc,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sr;
  logic              odd;
  logic              lbl_ok;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (sin.vld) sr <= {sin.val, sr[WORD_W-1:1]};
  end

  always_comb begin
    odd    = ^sr;
    word   = {~odd, sr[WORD_W-2:0]};
    lbl_ok = !filt_en || (sr[LBL_LO +: LBL_W] == filt_bits);
    acc    = sin.eos && lbl_ok;
  end

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    sin.vld |=> sr[WORD_W-1] == $past(sin.val));
endmodule

// File: rtl/wordrx_hold.sv
module wordrx_hold #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [WORD_W-1:0] word,
  input  logic              rd_en,
  input  logic              sel,
  output logic [WORD_W-1:0] latch,
  output logic              rdy_n
);
  logic en_q;
  logic sel_q;
  logic got_lo;
  logic trail;

  assign trail = en_q && !rd_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch  <= '0;
      rdy_n  <= 1'b1;
      got_lo <= 1'b0;
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      en_q <= rd_en;
      if (rd_en) sel_q <= sel;
      if (acc) begin
        latch  <= word;
        rdy_n  <= 1'b0;
        got_lo <= 1'b0;
      end else if (trail) begin
        if (!sel_q) begin
          got_lo <= 1'b1;
        end else if (got_lo) begin
          rdy_n  <= 1'b1;
          got_lo <= 1'b0;
        end
      end
    end
  end

  // R5
  load_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> (latch == $past(word)) && !rdy_n);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_n) |-> $past(!rd_en) && $past(rd_en, 2));
endmodule

// File: rtl/wordrx_busmux.sv
module wordrx_busmux #(
  parameter int NCH    = 2,
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2,
  localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        rd_en,
  input  logic                  sel,
  input  logic [NCH*WORD_W-1:0] lat_flat,
  output logic [HALF_W-1:0]     dout,
  output logic                  dout_vld
);
  logic [IDX_W-1:0]  pick;
  logic              any;
  logic [HALF_W-1:0] half;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (rd_en[i]) begin
        pick = IDX_W'(i);
        any  = 1'b1;
      end
    end
    if (sel) half = lat_flat[int'(pick)*WORD_W + HALF_W +: HALF_W];
    else     half = lat_flat[int'(pick)*WORD_W +: HALF_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= any;
      if (any) dout <= half;
    end
  end

  // R10
  vld_chk: assert property (@(posedge clk) disable iff (rst)
    (|rd_en) |=> dout_vld);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(|rd_en) |=> !dout_vld);
endmodule

// File: rtl/wordrx_dual_top.sv
module wordrx_dual_top
  import wordrx_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int WORD_W = 32,
  parameter int LBL_LO = 8,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    bit_vld,
  input  logic [NCH-1:0]    bit_val,
  input  logic [NCH-1:0]    eos,
  input  logic              filt_en,
  input  logic [LBL_W-1:0]  filt_bits,
  input  logic [NCH-1:0]    rd_en,
  input  logic              sel,
  output logic [HALF_W-1:0] dout,
  output logic              dout_vld,
  output logic [NCH-1:0]    rdy_n
);
  logic [NCH*WORD_W-1:0] lat_flat;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ser_in_t           sin;
    logic              acc;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] latch;

    assign sin = '{vld: bit_vld[c], val: bit_val[c], eos: eos[c]};

    wordrx_shifter #(.WORD_W(WORD_W), .LBL_LO(LBL_LO)) u_shf (
      .clk(clk), .rst(rst), .sin(sin), .filt_en(filt_en),
      .filt_bits(filt_bits), .acc(acc), .word(word)
    );

    wordrx_hold #(.WORD_W(WORD_W)) u_hold (
      .clk(clk), .rst(rst), .acc(acc), .word(word), .rd_en(rd_en[c]),
      .sel(sel), .latch(latch), .rdy_n(rdy_n[c])
    );

    assign lat_flat[c*WORD_W +: WORD_W] = latch;
  end

  wordrx_busmux #(.NCH(NCH), .WORD_W(WORD_W)) u_mux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .lat_flat(lat_flat),
    .dout(dout), .dout_vld(dout_vld)
  );
endmodule

// File: tb/sim_wordrx_dual_top.sv
`timescale 1ns/1ps
module sim_wordrx_dual_top;
  localparam int NCH = 2;
  localparam int W   = 32;
  localparam int H   = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst;
  logic [NCH-1:0] bit_vld, bit_val, eos, rd_en, rdy_n;
  logic           filt_en, sel, dout_vld;
  logic [1:0]     filt_bits;
  logic [H-1:0]   dout;

  wordrx_dual_top u0 (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val), .eos(eos),
    .filt_en(filt_en), .filt_bits(filt_bits), .rd_en(rd_en), .sel(sel),
    .dout(dout), .dout_vld(dout_vld), .rdy_n(rdy_n)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [W-1:0] m_latch [NCH];
  logic         m_rdy   [NCH];
  bit           m_lo    [NCH];
  bit           m_enp   [NCH];
  bit           m_sel   [NCH];
  logic [H-1:0] m_dout;
  logic         m_vld;
  bit           m_live = 0;
  bit           hist0[$];
  bit           hist1[$];
  int           pick, ones;
  logic [W-1:0] w;

  function automatic logic [W-1:0] last_word(int ch);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (ch == 0) r[i] = hist0[hist0.size() - W + i];
      else         r[i] = hist1[hist1.size() - W + i];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist0.delete();
      hist1.delete();
      for (int i = 0; i < W; i++) begin
        hist0.push_back(1'b0);
        hist1.push_back(1'b0);
      end
      for (int c = 0; c < NCH; c++) begin
        m_latch[c] = '0; m_rdy[c] = 1'b1; m_lo[c] = 0; m_enp[c] = 0; m_sel[c] = 0;
      end
      m_vld  = 1'b0;
      m_live = 1;
    end else begin
      m_vld  = |rd_en;
      pick   = rd_en[0] ? 0 : 1;
      m_dout = sel ? m_latch[pick][31:16] : m_latch[pick][15:0];
      for (int c = 0; c < NCH; c++) begin
        if (m_enp[c] && !rd_en[c]) begin
          if (!m_sel[c]) m_lo[c] = 1;
          else if (m_lo[c]) begin m_rdy[c] = 1'b1; m_lo[c] = 0; end
        end
        if (rd_en[c]) m_sel[c] = sel;
        m_enp[c] = rd_en[c];
        if (eos[c]) begin
          w    = last_word(c);
          ones = $countones(w);
          w[31] = (ones % 2 == 1) ? 1'b0 : 1'b1;
          if (!filt_en || (w[8] == filt_bits[0] && w[9] == filt_bits[1])) begin
            m_latch[c] = w; m_rdy[c] = 1'b0; m_lo[c] = 0;
          end
        end
        if (bit_vld[c]) begin
          if (c == 0) begin hist0.push_back(bit_val[c]); if (hist0.size() > 64) void'(hist0.pop_front()); end
          else        begin hist1.push_back(bit_val[c]); if (hist1.size() > 64) void'(hist1.pop_front()); end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (m_live && !rst && !done) begin
      chk("R10 dout_vld per cycle", {31'b0, dout_vld}, {31'b0, m_vld});
      if (m_vld) chk("R6 dout per cycle", {16'b0, dout}, {16'b0, m_dout});
      for (int c = 0; c < NCH; c++)
        chk("R7 rdy_n per cycle", {31'b0, rdy_n[c]}, {31'b0, m_rdy[c]});
    end
  end

  task automatic send_word(int ch, logic [W-1:0] v);
    for (int i = 0; i < W; i++) begin
      @(negedge clk); bit_vld[ch] = 1'b1; bit_val[ch] = v[i];
    end
    @(negedge clk); bit_vld[ch] = 1'b0; bit_val[ch] = 1'b0; eos[ch] = 1'b1;
    @(negedge clk); eos[ch] = 1'b0;
  endtask

  task automatic rd(int ch, bit s, output logic [H-1:0] v);
    @(negedge clk); rd_en[ch] = 1'b1; sel = s;
    @(negedge clk); v = dout; rd_en[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [H-1:0] v;
    rst = 1'b1; bit_vld = '0; bit_val = '0; eos = '0; rd_en = '0;
    sel = 1'b0; filt_en = 1'b0; filt_bits = 2'b00;
    repeat (4) @(negedge clk);
    chk("R11 rdy_n reset", {30'b0, rdy_n}, 32'h3);
    chk("R11 dout_vld reset", {31'b0, dout_vld}, 32'h0);
    rst = 1'b0;
    rd(0, 0, v); chk("R11 held word zero", {16'b0, v}, 32'h0);

    // R4 R5 R1 R2 odd total
    send_word(0, 32'h0000_0301);
    chk("R5 R4 flag after accept", {31'b0, rdy_n[0]}, 32'h0);
    rd(0, 0, v); chk("R1 R6 low half", {16'b0, v}, 32'h0301);
    chk("R7 flag held after low only", {31'b0, rdy_n[0]}, 32'h0);
    rd(0, 1, v); chk("R2 odd ones gives 0", {16'b0, v}, 32'h0000);
    chk("R7 flag cleared", {31'b0, rdy_n[0]}, 32'h1);

    // R2 even total, R8 order
    send_word(1, 32'h0000_0300);
    rd(1, 1, v); chk("R2 even ones gives 1", {16'b0, v}, 32'h8000);
    chk("R8 high first no effect", {31'b0, rdy_n[1]}, 32'h0);
    rd(1, 0, v); chk("R6 ch1 low", {16'b0, v}, 32'h0300);
    rd(1, 1, v); chk("R7 ch1 cleared", {31'b0, rdy_n[1]}, 32'h1);

    // R9 overwrite mid read
    send_word(1, 32'h0000_0301);
    rd(1, 0, v);
    send_word(1, 32'h1234_0000);
    rd(1, 1, v); chk("R9 overwritten word", {16'b0, v}, 32'h1234);
    chk("R9 sequence restarted", {31'b0, rdy_n[1]}, 32'h0);
    rd(1, 0, v); rd(1, 1, v);
    chk("R9 clears after fresh pair", {31'b0, rdy_n[1]}, 32'h1);

    // R3 filter
    filt_en = 1'b1; filt_bits = 2'b01;
    send_word(0, 32'h0000_0300);
    chk("R3 rejected flag", {31'b0, rdy_n[0]}, 32'h1);
    rd(0, 0, v); chk("R3 rejected latch kept", {16'b0, v}, 32'h0301);
    send_word(0, 32'h0000_0100);
    chk("R3 matched accepted", {31'b0, rdy_n[0]}, 32'h0);
    rd(0, 0, v); chk("R3 matched word", {16'b0, v}, 32'h0100);
    rd(0, 1, v);

    // R10 priority
    @(negedge clk); rd_en = 2'b11; sel = 1'b0;
    @(negedge clk); chk("R10 ch0 priority", {16'b0, dout}, 32'h0100);
    rd_en = 2'b00;
    @(negedge clk); @(negedge clk);
    chk("R10 idle bus", {31'b0, dout_vld}, 32'h0);

    // R12 eos with a bit
    filt_en = 1'b0;
    for (int i = 0; i < W; i++) begin
      @(negedge clk); bit_vld[0] = 1'b1; bit_val[0] = (i >= 4 && i < 8);
    end
    @(negedge clk); bit_vld[0] = 1'b1; bit_val[0] = 1'b1; eos[0] = 1'b1;
    @(negedge clk); bit_vld[0] = 1'b0; bit_val[0] = 1'b0; eos[0] = 1'b0;
    rd(0, 0, v); chk("R12 low half pre-shift", {16'b0, v}, 32'h00F0);
    rd(0, 1, v); chk("R12 high half pre-shift", {16'b0, v}, 32'h8000);

    // randomized phase, checked by the reference every cycle
    for (int k = 0; k < 40; k++) begin
      filt_en   = ($urandom % 4) == 0;
      filt_bits = 2'($urandom);
      send_word(int'($urandom % 2), $urandom);
      for (int r = 0; r < int'($urandom % 4); r++) begin
        @(negedge clk); rd_en = 2'($urandom % 4); sel = 1'($urandom);
        @(negedge clk); rd_en = '0;
      end
    end
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule